// File: doc/BRIEF.md
# Per-Line Pad Ownership and Routing Datapath

This block sits between a bank of I/O pads and the logic that wants to use them. Each of its `LINES` lanes hands its pad either to a processor-driven parallel I/O function or to one of two on-chip peripherals, called A and B. For each lane it produces the pad data, an active-low pad drive enable, an active-high input-buffer enable, and the data returned to each peripheral. All settings arrive as plain per-lane bit vectors from a configuration register bank outside this block. That bank holds the reset state: every lane owned by parallel I/O, peripheral A chosen, open drain off, input buffer on, no loops.

Two options change how a lane drives and receives. In open-drain mode the lane can only pull low, and this works whichever function owns the pad. In loop mode one peripheral's output is fed back as the other peripheral's input, so the two can talk without going through the pin. The block is purely combinational, so each output responds to its inputs in the same cycle.

Top module: `pin_route_bank`

## Requirements
- R1: With `own_gpio`=1 and `open_drain`=0, `pad_dout` equals `gpio_val` and `pad_oe_n` equals the inverse of `gpio_oe`. `sel_b` and all peripheral outputs have no effect on the pad.
- R2: With `own_gpio`=1, `a_din` and `b_din` are 0 whatever the pad level and the loop bits.
- R3: With `own_gpio`=0, `sel_b`=0 and `open_drain`=0, `pad_dout` follows `a_dout` and `pad_oe_n` follows `a_oe_n`. Peripheral B's outputs have no effect on the pad.
- R4: With `own_gpio`=0, `sel_b`=1 and `open_drain`=0, `pad_dout` follows `b_dout` and `pad_oe_n` follows `b_oe_n`. Peripheral A's outputs have no effect on the pad.
- R5: With `open_drain`=1, `pad_dout` is 0. `pad_oe_n` is 0 only when the owning source enables its driver and its data is 0. This holds on both the parallel I/O path and the peripheral path.
- R6: `pad_ie` is the inverse of `inbuf_off` on every lane, in every ownership mode.
- R7: With `own_gpio`=0 and neither loop bit set, `a_din` and `b_din` both carry `pad_din`. This includes the peripheral that does not own the pad.
- R8: With `own_gpio`=0 and `loop_a`=1, `b_din` carries `a_dout` instead of the pad level.
- R9: With `own_gpio`=0 and `loop_b`=1, `a_din` carries `b_dout` instead of the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| own_gpio | input | LINES | 1 = lane owned by parallel I/O, 0 = owned by a peripheral |
| gpio_oe | input | LINES | Parallel I/O driver enable, active high |
| gpio_val | input | LINES | Parallel I/O output value |
| sel_b | input | LINES | 0 = peripheral A owns the lane, 1 = peripheral B |
| open_drain | input | LINES | 1 = lane may only pull low |
| inbuf_off | input | LINES | 1 = disable pad input buffer |
| loop_a | input | LINES | 1 = A's output feeds B's input |
| loop_b | input | LINES | 1 = B's output feeds A's input |
| a_dout | input | LINES | Peripheral A output data |
| a_oe_n | input | LINES | Peripheral A driver enable, active low |
| b_dout | input | LINES | Peripheral B output data |
| b_oe_n | input | LINES | Peripheral B driver enable, active low |
| pad_din | input | LINES | Level sampled from the pad |
| pad_dout | output | LINES | Data driven toward the pad |
| pad_oe_n | output | LINES | Pad driver enable, active low |
| pad_ie | output | LINES | Pad input-buffer enable, active high |
| a_din | output | LINES | Data returned to peripheral A |
| b_din | output | LINES | Data returned to peripheral B |

## Verification
The assertions are immediate checks on settled combinational values. They assume every configuration and peripheral input is a known 0 or 1 and is held steady while it is sampled. The stimulus meets this by applying one complete 13-bit lane pattern to all inputs at once and letting it settle for a full clock before sampling. Each lane receives a different rotation of the same sweep, so every lane sees all 8192 combinations of its own inputs, including both loop bits set together.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;

  typedef struct packed {
    logic oe_n;
    logic d;
  } drv_t;

  // choose the source that owns the lane
  function automatic drv_t pick_owner(input logic gpio, input logic g_oe,
                                      input logic g_val, input logic use_b,
                                      input logic ad, input logic aoen,
                                      input logic bd, input logic boen);
    drv_t r;
    if (gpio) begin
      r.oe_n = ~g_oe;
      r.d    = g_val;
    end else if (use_b) begin
      r.oe_n = boen;
      r.d    = bd;
    end else begin
      r.oe_n = aoen;
      r.d    = ad;
    end
    return r;
  endfunction

  // open drain: enable only to pull low, data line held at 0
  function automatic drv_t shape_drive(input drv_t s, input logic od);
    drv_t r;
    if (od) begin
      r.oe_n = s.oe_n | s.d;
      r.d    = 1'b0;
    end else begin
      r = s;
    end
    return r;
  endfunction

  // data returned to one peripheral
  function automatic logic feed_back(input logic gpio, input logic looped,
                                     input logic other_out, input logic pad);
    if (gpio) return 1'b0;
    return looped ? other_out : pad;
  endfunction

endpackage

// File: rtl/pin_src_mux.sv
module pin_src_mux
  import pin_route_pkg::*;
(
  input  logic gpio,
  input  logic g_oe,
  input  logic g_val,
  input  logic use_b,
  input  logic ad,
  input  logic aoen,
  input  logic bd,
  input  logic boen,
  output drv_t src
);
  always_comb src = pick_owner(gpio, g_oe, g_val, use_b, ad, aoen, bd, boen);
endmodule

// File: rtl/pin_drive_stage.sv
module pin_drive_stage
  import pin_route_pkg::*;
(
  input  drv_t src,
  input  logic od,
  input  logic buf_off,
  output logic dout,
  output logic oe_n,
  output logic ie
);
  drv_t shaped;
  always_comb begin
    shaped = shape_drive(src, od);
    dout   = shaped.d;
    oe_n   = shaped.oe_n;
    ie     = ~buf_off;
  end

  always_comb begin
    if (od) begin
      AST_OD_DATA_LOW: assert (dout == 1'b0); // R5
    end
    if (od && !oe_n) begin
      AST_OD_ONLY_SINKS: assert (src.d == 1'b0 && src.oe_n == 1'b0); // R5
    end
  end
endmodule

// File: rtl/pin_return_path.sv
module pin_return_path
  import pin_route_pkg::*;
(
  input  logic gpio,
  input  logic lp_a,
  input  logic lp_b,
  input  logic ad,
  input  logic bd,
  input  logic pad,
  output logic to_a,
  output logic to_b
);
  always_comb begin
    to_a = feed_back(gpio, lp_b, bd, pad);
    to_b = feed_back(gpio, lp_a, ad, pad);
  end
endmodule

// File: rtl/pin_route_bank.sv
module pin_route_bank
  import pin_route_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0] own_gpio,
  input  logic [LINES-1:0] gpio_oe,
  input  logic [LINES-1:0] gpio_val,
  input  logic [LINES-1:0] sel_b,
  input  logic [LINES-1:0] open_drain,
  input  logic [LINES-1:0] inbuf_off,
  input  logic [LINES-1:0] loop_a,
  input  logic [LINES-1:0] loop_b,
  input  logic [LINES-1:0] a_dout,
  input  logic [LINES-1:0] a_oe_n,
  input  logic [LINES-1:0] b_dout,
  input  logic [LINES-1:0] b_oe_n,
  input  logic [LINES-1:0] pad_din,
  output logic [LINES-1:0] pad_dout,
  output logic [LINES-1:0] pad_oe_n,
  output logic [LINES-1:0] pad_ie,
  output logic [LINES-1:0] a_din,
  output logic [LINES-1:0] b_din
);

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    drv_t owner_drv;

    pin_src_mux u_mux (
      .gpio (own_gpio[i]),
      .g_oe (gpio_oe[i]),
      .g_val(gpio_val[i]),
      .use_b(sel_b[i]),
      .ad   (a_dout[i]),
      .aoen (a_oe_n[i]),
      .bd   (b_dout[i]),
      .boen (b_oe_n[i]),
      .src  (owner_drv)
    );

    pin_drive_stage u_drv (
      .src    (owner_drv),
      .od     (open_drain[i]),
      .buf_off(inbuf_off[i]),
      .dout   (pad_dout[i]),
      .oe_n   (pad_oe_n[i]),
      .ie     (pad_ie[i])
    );

    pin_return_path u_ret (
      .gpio(own_gpio[i]),
      .lp_a(loop_a[i]),
      .lp_b(loop_b[i]),
      .ad  (a_dout[i]),
      .bd  (b_dout[i]),
      .pad (pad_din[i]),
      .to_a(a_din[i]),
      .to_b(b_din[i])
    );

    always_comb begin
      if (own_gpio[i]) begin
        AST_GPIO_RETURNS_ZERO: assert (a_din[i] == 1'b0 && b_din[i] == 1'b0); // R2
      end
      if (own_gpio[i] && !open_drain[i]) begin
        AST_GPIO_ENABLE: assert (pad_oe_n[i] == ~gpio_oe[i]); // R1
      end
      if (!own_gpio[i] && !open_drain[i] && !sel_b[i]) begin
        AST_A_OWNS_PAD: assert (pad_oe_n[i] == a_oe_n[i] && pad_dout[i] == a_dout[i]); // R3
      end
      if (!own_gpio[i] && !open_drain[i] && sel_b[i]) begin
        AST_B_OWNS_PAD: assert (pad_oe_n[i] == b_oe_n[i] && pad_dout[i] == b_dout[i]); // R4
      end
      AST_INBUF_ENABLE: assert (pad_ie[i] != inbuf_off[i]); // R6
    end
  end

endmodule

// File: tb/pin_route_bank_tb_top.sv
module pin_route_bank_tb_top;
  localparam int LINES = 32;
  localparam int VBITS = 13;
  localparam int NVEC  = 1 << VBITS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [LINES-1:0] own_gpio, gpio_oe, gpio_val, sel_b, open_drain, inbuf_off;
  logic [LINES-1:0] loop_a, loop_b, a_dout, a_oe_n, b_dout, b_oe_n, pad_din;
  logic [LINES-1:0] pad_dout, pad_oe_n, pad_ie, a_din, b_din;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 0;

  pin_route_bank #(.LINES(LINES)) dut_i (
    .own_gpio(own_gpio), .gpio_oe(gpio_oe), .gpio_val(gpio_val), .sel_b(sel_b),
    .open_drain(open_drain), .inbuf_off(inbuf_off), .loop_a(loop_a), .loop_b(loop_b),
    .a_dout(a_dout), .a_oe_n(a_oe_n), .b_dout(b_dout), .b_oe_n(b_oe_n),
    .pad_din(pad_din), .pad_dout(pad_dout), .pad_oe_n(pad_oe_n), .pad_ie(pad_ie),
    .a_din(a_din), .b_din(b_din)
  );

  task automatic check(input string tag, input int lane, input string what,
                       input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s lane %0d %s: actual=%b expected=%b", tag, lane, what, got, exp);
    end
  endtask

  // pattern bits: 0 own_gpio,1 gpio_oe,2 gpio_val,3 sel_b,4 open_drain,5 inbuf_off,
  // 6 loop_a,7 loop_b,8 a_dout,9 a_oe_n,10 b_dout,11 b_oe_n,12 pad_din
  function automatic logic [VBITS-1:0] lane_pat(input int v, input int lane);
    return VBITS'((v + lane * 1237) % NVEC);
  endfunction

  task automatic apply(input int v);
    for (int i = 0; i < LINES; i++) begin
      logic [VBITS-1:0] p;
      p = lane_pat(v, i);
      own_gpio[i] = p[0];  gpio_oe[i] = p[1];  gpio_val[i] = p[2];
      sel_b[i] = p[3];     open_drain[i] = p[4]; inbuf_off[i] = p[5];
      loop_a[i] = p[6];    loop_b[i] = p[7];   a_dout[i] = p[8];
      a_oe_n[i] = p[9];    b_dout[i] = p[10];  b_oe_n[i] = p[11];
      pad_din[i] = p[12];
    end
  endtask

  task automatic verify(input int v);
    for (int i = 0; i < LINES; i++) begin
      logic [VBITS-1:0] p;
      int en, val, e_oen, e_d, e_a, e_b;
      string tag;
      p = lane_pat(v, i);
      // drive request of the owner, 1 = driving
      if (p[0]) begin en = p[1]; val = p[2]; tag = "R1"; end
      else if (p[3]) begin en = 1 - p[11]; val = p[10]; tag = "R4"; end
      else begin en = 1 - p[9]; val = p[8]; tag = "R3"; end
      if (p[4]) begin
        tag = "R5";
        e_d = 0;
        e_oen = (en * (1 - val) == 1) ? 0 : 1;
      end else begin
        e_d = val;
        e_oen = 1 - en;
      end
      check(tag, i, "pad_oe_n", pad_oe_n[i], e_oen[0]);
      check(tag, i, "pad_dout", pad_dout[i], e_d[0]);
      check("R6", i, "pad_ie", pad_ie[i], ~p[5]);
      if (p[0]) begin
        check("R2", i, "a_din", a_din[i], 1'b0);
        check("R2", i, "b_din", b_din[i], 1'b0);
      end else begin
        e_a = p[7] ? p[10] : p[12];
        e_b = p[6] ? p[8] : p[12];
        check(p[7] ? "R9" : "R7", i, "a_din", a_din[i], e_a[0]);
        check(p[6] ? "R8" : "R7", i, "b_din", b_din[i], e_b[0]);
      end
    end
  endtask

  initial begin
    // reset-state configuration: all lanes parallel I/O, inputs, A, no options
    own_gpio = '1; gpio_oe = '0; gpio_val = '0; sel_b = '0; open_drain = '0;
    inbuf_off = '0; loop_a = '0; loop_b = '0; a_dout = '1; a_oe_n = '0;
    b_dout = '1; b_oe_n = '0; pad_din = '1;
    @(negedge clk);
    for (int i = 0; i < LINES; i++) begin
      check("R1", i, "reset pad_oe_n", pad_oe_n[i], 1'b1);
      check("R6", i, "reset pad_ie", pad_ie[i], 1'b1);
      check("R2", i, "reset a_din", a_din[i], 1'b0);
    end
    for (int v = 0; v < NVEC; v++) begin
      apply(v);
      @(negedge clk);
      verify(v);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule